// File: doc/BRIEF.md
# Single-Wire Sensor Bus Slave Transaction Engine

This block is the framing and transaction layer of a slave on a single-wire sensor bus. A physical-layer front end turns line activity into a `frame_start` pulse and a stream of decoded bits, each marked by a one-cycle `bit_vld` strobe. The engine parses each frame in this order: header, data, parity, acknowledge. The header holds a 3-bit device number, a 7-bit register address and a direction bit. The engine decides whether the frame is addressed to it. On reads it serialises register contents and an even-parity bit back onto the line. On writes it checks the parity, answers with its own acknowledge, and only then commits the word to a simple register-file port.

The register file is external. While the header arrives it sees the address on `rf_addr`. It answers combinationally with the read word and a width flag that selects an 8-bit or a 16-bit data field. A sticky error flag records every frame that did not finish cleanly. An attention request tells the master to come and look, and it stays up until the next frame start has been presented.

Top module: `sbus_txn_slave`

## Requirements
- R1: After reset, `ber`, `attn`, `rf_we` and `drv_en` are all 0.
- R2: A frame follows a `frame_start` pulse. Its header is sent most significant bit first, in this order: a 3-bit device number, a 7-bit address, then a direction bit (1 = read, 0 = write). The data field that follows is sent MSB first. It is 16 bits wide when `rf_wide` is 1 for the address and 8 bits wide otherwise.
- R3: A read addressed to `my_dev` drives the line (`drv_en` = 1) in every data slot and in the parity slot. The data slots carry the register word MSB first; a narrow read sends `rf_rdata[7:0]`. The parity bit makes the count of ones over device number, address, direction bit, data and parity even.
- R4: A read with device number 0, and any frame whose device number is neither `my_dev` nor 0, leave `drv_en` at 0 for the whole frame, produce no write and raise no error.
- R5: A write addressed to `my_dev` with correct parity gets an acknowledge of 1, driven by the slave in the acknowledge slot. `rf_we` then pulses for exactly one cycle, the cycle after the acknowledge strobe. During that pulse `rf_wdata` holds the received word (a narrow word in bits 7:0 with zeros above) and `rf_addr` holds the frame address.
- R6: A write with wrong parity is answered with an acknowledge of 0. It produces no `rf_we` and sets `ber` and `attn`.
- R7: A write with device number 0 is accepted and committed only when its address equals `CTRL_ADDR`. For any other address it is ignored: no drive, no write, no error.
- R8: On a read, an acknowledge of 0 from the master sets `ber` and `attn`. An acknowledge of 1 changes neither.
- R9: A `frame_start` that arrives during the data, parity or acknowledge slots of an accepted frame abandons that frame without a write, sets `ber` and `attn`, and begins parsing a new header.
- R10: `ber` stays set until `ber_clr` is asserted, and an error in the same cycle wins over the clear.
- R11: `attn` rises the cycle after an error. It is still 1 in the cycle in which the next `frame_start` is presented and falls the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| bit_vld | input | 1 | Strobe closing one bit slot |
| bit_val | input | 1 | Decoded line value of the slot |
| my_dev | input | 3 | Own device number (nonzero) |
| rf_addr | output | 7 | Register address of the current frame |
| rf_wide | input | 1 | Register at `rf_addr` is 16 bits wide |
| rf_rdata | input | 16 | Read word for `rf_addr` |
| rf_we | output | 1 | One-cycle commit strobe |
| rf_wdata | output | 16 | Committed write word |
| drv_en | output | 1 | Slave owns the line in the current slot |
| drv_bit | output | 1 | Value to drive in the current slot |
| ber_clr | input | 1 | Clears the bus-error flag |
| ber | output | 1 | Sticky bus-error flag |
| attn | output | 1 | Attention request to the master |

## Verification
`drv_en` and `drv_bit` come only from registers. They describe the slot that the next `bit_vld` strobe will close, so the bench reads them before it raises that strobe. `rf_we`, `rf_wdata`, `ber` and `attn` change one cycle after the strobe or start pulse that causes them. The bench drives on falling edges and reads these outputs on the falling edge that follows. The write scoreboard pops its expected address and word only in the cycle in which `rf_we` is seen high. The fall of `attn` is checked in two steps: once in the cycle that carries `frame_start`, and once in the cycle after it.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int DEV_W  = 3;
  localparam int ADDR_W = 7;
  localparam int HDR_W  = DEV_W + ADDR_W;

  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_DATA, PH_PAR, PH_ACK, PH_SKIP
  } phase_t;

  // Frame acceptance: own number always; number zero only for control writes.
  function automatic logic frame_hits(input logic [DEV_W-1:0] dev,
                                      input logic [ADDR_W-1:0] addr,
                                      input logic rd,
                                      input logic [DEV_W-1:0] own,
                                      input logic [ADDR_W-1:0] ctrl);
    if (dev == '0) return !rd && (addr == ctrl);
    return dev == own;
  endfunction

  // Parity contribution of the header fields and the direction bit.
  function automatic logic hdr_parity(input logic [HDR_W-1:0] hdr, input logic rd);
    return ^{hdr, rd};
  endfunction
endpackage

// File: rtl/sbus_frame_fsm.sv
module sbus_frame_fsm import sbus_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic [DEV_W-1:0] my_dev,
  input  logic             rf_wide,
  input  logic             perr,
  output phase_t           phase,
  output logic             is_rd,
  output logic [HDR_W-1:0] hdr,
  output logic             load_evt,
  output logic             data_evt,
  output logic             par_evt,
  output logic             commit_evt,
  output logic             err_evt
);
  localparam int SPAN  = (DATA_W > HDR_W + 1) ? DATA_W : HDR_W + 1;
  localparam int CNT_W = $clog2(SPAN + 1);

  logic [CNT_W-1:0] cnt;
  logic             wide;
  logic             strobe, hdr_last, hit, data_last, ack_evt, active;

  always_comb begin
    strobe     = bit_vld && !frame_start;
    hdr_last   = (phase == PH_HDR) && strobe && (cnt == CNT_W'(HDR_W));
    hit        = frame_hits(hdr[HDR_W-1 -: DEV_W], hdr[ADDR_W-1:0], bit_val,
                            my_dev, CTRL_ADDR);
    load_evt   = hdr_last && hit;
    data_evt   = (phase == PH_DATA) && strobe;
    data_last  = cnt == (wide ? CNT_W'(DATA_W - 1) : CNT_W'(NARROW_W - 1));
    par_evt    = (phase == PH_PAR) && strobe;
    ack_evt    = (phase == PH_ACK) && strobe;
    commit_evt = ack_evt && !is_rd && !perr;
    active     = (phase == PH_DATA) || (phase == PH_PAR) || (phase == PH_ACK);
    err_evt    = (ack_evt && (is_rd ? !bit_val : perr)) || (frame_start && active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      hdr   <= '0;
      is_rd <= 1'b0;
      wide  <= 1'b0;
    end else if (frame_start) begin
      phase <= PH_HDR;
      cnt   <= '0;
    end else if (bit_vld) begin
      case (phase)
        PH_HDR: begin
          if (!hdr_last) begin
            hdr <= {hdr[HDR_W-2:0], bit_val};
            cnt <= cnt + 1'b1;
          end else begin
            is_rd <= bit_val;
            wide  <= rf_wide;
            cnt   <= '0;
            phase <= hit ? PH_DATA : PH_SKIP;
          end
        end
        PH_DATA: begin
          cnt <= cnt + 1'b1;
          if (data_last) phase <= PH_PAR;
        end
        PH_PAR:  phase <= PH_ACK;
        PH_ACK:  phase <= PH_IDLE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbus_data_path.sv
module sbus_data_path #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_val,
  input  logic              is_rd,
  input  logic              rf_wide,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic              load_evt,
  input  logic              data_evt,
  input  logic              par_evt,
  input  logic              par_seed,
  output logic              tx_bit,
  output logic              par_bit,
  output logic              perr,
  output logic [DATA_W-1:0] rx_word
);
  localparam int PAD = DATA_W - NARROW_W;

  logic [DATA_W-1:0] tx_q;

  // Narrow words move to the top so the shifter always emits from the MSB.
  function automatic logic [DATA_W-1:0] left_align(input logic [DATA_W-1:0] w,
                                                   input logic wide);
    return wide ? w : (w << PAD);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_word <= '0;
      par_bit <= 1'b0;
      perr    <= 1'b0;
    end else if (load_evt) begin
      tx_q    <= left_align(rf_rdata, rf_wide);
      rx_word <= '0;
      par_bit <= par_seed;
      perr    <= 1'b0;
    end else if (data_evt) begin
      if (is_rd) begin
        par_bit <= par_bit ^ tx_q[DATA_W-1];
        tx_q    <= {tx_q[DATA_W-2:0], 1'b0};
      end else begin
        par_bit <= par_bit ^ bit_val;
        rx_word <= {rx_word[DATA_W-2:0], bit_val};
      end
    end else if (par_evt && !is_rd) begin
      perr <= par_bit ^ bit_val;
    end
  end

  assign tx_bit = tx_q[DATA_W-1];
endmodule

// File: rtl/sbus_status_commit.sv
module sbus_status_commit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_evt,
  input  logic              err_evt,
  input  logic              frame_start,
  input  logic              ber_clr,
  input  logic [DATA_W-1:0] rx_word,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              ber,
  output logic              attn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_we    <= 1'b0;
      rf_wdata <= '0;
      ber      <= 1'b0;
      attn     <= 1'b0;
    end else begin
      rf_we <= commit_evt;
      if (commit_evt) rf_wdata <= rx_word;
      if (err_evt)      ber <= 1'b1;
      else if (ber_clr) ber <= 1'b0;
      if (err_evt)          attn <= 1'b1;
      else if (frame_start) attn <= 1'b0;
    end
  end
endmodule

// File: rtl/sbus_txn_slave.sv
module sbus_txn_slave import sbus_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic [DEV_W-1:0]  my_dev,
  output logic [ADDR_W-1:0] rf_addr,
  input  logic              rf_wide,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              drv_en,
  output logic              drv_bit,
  input  logic              ber_clr,
  output logic              ber,
  output logic              attn
);
  phase_t             phase;
  logic               is_rd, perr, tx_bit, par_bit, par_seed;
  logic [HDR_W-1:0]   hdr;
  logic [DEV_W-1:0]   hdr_dev;
  logic               load_evt, data_evt, par_evt, commit_evt, err_evt;
  logic [DATA_W-1:0]  rx_word;

  assign hdr_dev  = hdr[HDR_W-1 -: DEV_W];
  assign rf_addr  = hdr[ADDR_W-1:0];
  assign par_seed = hdr_parity(hdr, bit_val);

  sbus_frame_fsm #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CTRL_ADDR(CTRL_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_vld(bit_vld),
    .bit_val(bit_val), .my_dev(my_dev), .rf_wide(rf_wide), .perr(perr),
    .phase(phase), .is_rd(is_rd), .hdr(hdr), .load_evt(load_evt),
    .data_evt(data_evt), .par_evt(par_evt), .commit_evt(commit_evt),
    .err_evt(err_evt)
  );

  sbus_data_path #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .bit_val(bit_val), .is_rd(is_rd),
    .rf_wide(rf_wide), .rf_rdata(rf_rdata), .load_evt(load_evt),
    .data_evt(data_evt), .par_evt(par_evt), .par_seed(par_seed),
    .tx_bit(tx_bit), .par_bit(par_bit), .perr(perr), .rx_word(rx_word)
  );

  sbus_status_commit #(.DATA_W(DATA_W)) u_st (
    .clk(clk), .rst_n(rst_n), .commit_evt(commit_evt), .err_evt(err_evt),
    .frame_start(frame_start), .ber_clr(ber_clr), .rx_word(rx_word),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .ber(ber), .attn(attn)
  );

  // Line ownership: data and parity on reads, acknowledge on writes.
  always_comb begin
    drv_en  = 1'b0;
    drv_bit = 1'b0;
    case (phase)
      PH_DATA: begin drv_en = is_rd;  drv_bit = tx_bit;  end
      PH_PAR:  begin drv_en = is_rd;  drv_bit = par_bit; end
      PH_ACK:  begin drv_en = !is_rd; drv_bit = !perr;   end
      default: ;
    endcase
  end
endmodule

// File: rtl/sbus_txn_slave_chk.sv
module sbus_txn_slave_chk import sbus_pkg::*; #(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              bit_vld,
  input logic              ber_clr,
  input logic              ber,
  input logic              attn,
  input logic              rf_we,
  input logic              drv_en,
  input logic              is_rd,
  input phase_t            phase,
  input logic [DEV_W-1:0]  hdr_dev,
  input logic [DEV_W-1:0]  my_dev,
  input logic [ADDR_W-1:0] rf_addr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !drv_en);

  a_r5_we_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(phase == PH_ACK && bit_vld && !frame_start && !is_rd));

  a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  a_r4_read_own_only: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && is_rd) |-> (hdr_dev == my_dev && hdr_dev != '0));

  a_r7_bcast_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_DATA || phase == PH_PAR || phase == PH_ACK) && hdr_dev == '0)
      |-> (!is_rd && rf_addr == CTRL_ADDR));

  a_r10_ber_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ber && !ber_clr) |=> ber);

  a_r11_attn_with_ber: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ber) |-> attn);
endmodule

bind sbus_txn_slave sbus_txn_slave_chk #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_vld(bit_vld),
  .ber_clr(ber_clr), .ber(ber), .attn(attn), .rf_we(rf_we), .drv_en(drv_en),
  .is_rd(is_rd), .phase(phase), .hdr_dev(hdr_dev), .my_dev(my_dev),
  .rf_addr(rf_addr)
);

// File: tb/sbus_txn_slave_tb.sv
module sbus_txn_slave_tb;
  localparam logic [6:0] CTRL = 7'h02;
  localparam logic [2:0] OWN  = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, bit_vld = 1'b0, bit_val = 1'b0, ber_clr = 1'b0;
  logic [2:0]  my_dev = OWN;
  logic [6:0]  rf_addr;
  logic        rf_wide, rf_we, drv_en, drv_bit, ber, attn;
  logic [15:0] rf_rdata, rf_wdata;

  int total = 0, bad = 0, wr_seen = 0;

  typedef struct { logic [6:0] a; logic [15:0] d; } wr_t;
  wr_t exp_q[$];

  always #2 clk = ~clk;

  function automatic logic [15:0] model_rd(input logic [6:0] a);
    return {a, 2'b10, ~a};
  endfunction

  assign rf_wide  = rf_addr[6];
  assign rf_rdata = model_rd(rf_addr);

  sbus_txn_slave #(.CTRL_ADDR(CTRL)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_vld(bit_vld),
    .bit_val(bit_val), .my_dev(my_dev), .rf_addr(rf_addr), .rf_wide(rf_wide),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata), .drv_en(drv_en),
    .drv_bit(drv_bit), .ber_clr(ber_clr), .ber(ber), .attn(attn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare each commit strobe against the scoreboard head.
  wr_t got;
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      wr_seen++;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 unexpected write act=%0h exp=none", rf_wdata);
      end else begin
        got = exp_q.pop_front();
        chk("R5 write addr", 32'(rf_addr), 32'(got.a));
        chk("R5 write data", 32'(rf_wdata), 32'(got.d));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic slot(input logic v, output logic de, output logic db);
    @(negedge clk);
    de = drv_en; db = drv_bit;
    bit_vld = 1'b1; bit_val = v;
    @(negedge clk);
    bit_vld = 1'b0; bit_val = 1'b0;
  endtask

  // Driver: plays one frame, checks slave-owned slots, pushes expected commits.
  task automatic send_frame(input logic [2:0] dev, input logic [6:0] a, input logic rd,
                            input logic [15:0] wd, input bit bad_par, input logic ack_in,
                            input bit sel, input string req, input int stop_after = -1);
    logic de, db;
    logic wide = a[6];
    int   len  = wide ? 16 : 8;
    logic [15:0] src  = rd ? model_rd(a) : wd;
    logic [15:0] word = wide ? src : {8'h00, src[7:0]};
    logic p = ^{dev, a, rd};
    start_pulse();
    for (int i = 2; i >= 0; i--) slot(dev[i], de, db);
    for (int i = 6; i >= 0; i--) slot(a[i], de, db);
    slot(rd, de, db);
    for (int i = len - 1; i >= 0; i--) begin
      if (stop_after >= 0 && (len - 1 - i) == stop_after) return;
      if (rd && sel) begin
        slot(1'b0, de, db);
        chk({req, " R3 read drive"}, 32'(de), 32'd1);
        chk({req, " R3 read bit"}, 32'(db), 32'(word[i]));
      end else begin
        slot(word[i], de, db);
        chk({req, " R4 silent in data"}, 32'(de), 32'd0);
      end
      p ^= word[i];
    end
    if (rd && sel) begin
      slot(1'b0, de, db);
      chk({req, " R3 parity drive"}, 32'(de), 32'd1);
      chk({req, " R3 parity bit"}, 32'(db), 32'(p));
    end else begin
      slot(p ^ bad_par, de, db);
      chk({req, " R4 silent in parity"}, 32'(de), 32'd0);
    end
    if (rd) begin
      slot(ack_in, de, db);
      chk({req, " R8 master owns ack"}, 32'(de), 32'd0);
    end else begin
      slot(1'b1, de, db);
      chk({req, " R5 ack drive"}, 32'(de), sel ? 32'd1 : 32'd0);
      if (sel) chk({req, " R6 ack value"}, 32'(db), bad_par ? 32'd0 : 32'd1);
      if (sel && !bad_par) exp_q.push_back('{a: a, d: word});
    end
    tick(2);
  endtask

  task automatic clear_ber();
    @(negedge clk); ber_clr = 1'b1;
    @(negedge clk); ber_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0;
    tick(3); rst_n = 1'b1; tick(1);
    chk("R1 ber", 32'(ber), 32'd0);
    chk("R1 attn", 32'(attn), 32'd0);
    chk("R1 rf_we", 32'(rf_we), 32'd0);
    chk("R1 drv_en", 32'(drv_en), 32'd0);

    send_frame(OWN, 7'h11, 1'b0, 16'h00A5, 0, 1'b1, 1, "R2 narrow write");
    send_frame(OWN, 7'h45, 1'b0, 16'hBEEF, 0, 1'b1, 1, "R2 wide write");
    send_frame(OWN, 7'h23, 1'b1, 16'h0, 0, 1'b1, 1, "R3 narrow read");
    send_frame(OWN, 7'h5A, 1'b1, 16'h0, 0, 1'b1, 1, "R3 wide read");
    chk("R8 good acks leave ber", 32'(ber), 32'd0);

    w0 = wr_seen;
    send_frame(3'd0, CTRL, 1'b1, 16'h0, 0, 1'b1, 0, "R4 broadcast read");
    send_frame(3'd3, 7'h23, 1'b1, 16'h0, 0, 1'b1, 0, "R4 foreign read");
    send_frame(3'd2, 7'h11, 1'b0, 16'h0055, 0, 1'b1, 0, "R4 foreign write");
    send_frame(3'd0, 7'h10, 1'b0, 16'h0066, 0, 1'b1, 0, "R7 broadcast other");
    chk("R4 R7 no writes", 32'(wr_seen - w0), 32'd0);
    chk("R4 R7 no error", 32'(ber), 32'd0);
    send_frame(3'd0, CTRL, 1'b0, 16'h003C, 0, 1'b1, 1, "R7 broadcast ctrl");
    chk("R7 ctrl committed", 32'(wr_seen - w0), 32'd1);

    w0 = wr_seen;
    send_frame(OWN, 7'h12, 1'b0, 16'h0011, 1, 1'b1, 1, "R6 bad parity");
    chk("R6 no write", 32'(wr_seen - w0), 32'd0);
    chk("R6 ber", 32'(ber), 32'd1);
    chk("R6 attn", 32'(attn), 32'd1);
    tick(5);
    chk("R10 sticky", 32'(ber), 32'd1);
    clear_ber();
    chk("R10 cleared", 32'(ber), 32'd0);
    chk("R11 attn held", 32'(attn), 32'd1);
    @(negedge clk); frame_start = 1'b1;
    chk("R11 attn at start", 32'(attn), 32'd1);
    @(negedge clk); frame_start = 1'b0;
    chk("R11 attn dropped", 32'(attn), 32'd0);

    send_frame(OWN, 7'h23, 1'b1, 16'h0, 0, 1'b0, 1, "R8 read nack");
    chk("R8 ber", 32'(ber), 32'd1);
    chk("R8 attn", 32'(attn), 32'd1);
    clear_ber();
    chk("R10 cleared again", 32'(ber), 32'd0);

    w0 = wr_seen;
    send_frame(OWN, 7'h13, 1'b0, 16'h0077, 0, 1'b1, 1, "R9 aborted", 3);
    chk("R9 no error before restart", 32'(ber), 32'd0);
    send_frame(OWN, 7'h14, 1'b0, 16'h0099, 0, 1'b1, 1, "R9 restart");
    chk("R9 ber", 32'(ber), 32'd1);
    chk("R9 single commit", 32'(wr_seen - w0), 32'd1);
    tick(3);
    chk("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule